// File: doc/BRIEF.md
# Oversampling Result Accumulator and Formatter

This block sits behind a converter sequencer and turns a burst of 10-bit samples into one 16-bit conversion result. Each sample arrives with a valid strobe and a polarity tag. Samples taken at inverted polarity, which happens when chopping is active, are mirrored about mid-scale before they are added, so that the converter offset cancels over the burst. An output sign-change control mirrors every sample as well. Because of this, a sample that is both inverted and sign-changed comes out unmirrored.

A start strobe clears the running sum and captures the configuration for the whole conversion: oversampling code, chop enable and sign change. The sequencer then delivers 2^n samples and marks the final one. On that final sample the block places the sum into a left-aligned 16-bit result and raises a one-cycle done pulse. The ten sample bits always occupy the top of the word. Each extra oversampling step adds one valid low bit and leaves the unused low bits at zero. At the largest code the sum is 17 bits wide and its lowest bit is dropped. Software recovers a right-aligned value by shifting the result right by 6 − min(6, n).

Top module: `osr_result_fmt`

## Requirements
- R1: After reset, `result_o` is 0 and `done_o` is 0.
- R2: A cycle with `start_i` high clears the running sum. A sample presented in that same cycle is dropped.
- R3: `osr_code_i`, `chop_en_i` and `sign_inv_i` are captured only in a cycle with `start_i` high. Changes to them during a conversion do not affect that conversion.
- R4: An accepted sample s is mirrored to 1023 − s when (captured chop enable AND `smp_inv_i`) XOR (captured sign change) is 1. Otherwise it is used unchanged.
- R5: Every cycle with `smp_valid_i` high and `start_i` low adds the corrected sample to the running sum. Cycles with `smp_valid_i` low add nothing.
- R6: For a captured oversampling code n from 0 to 6 (3-bit field, value n selects 2^n samples), the result is the sum shifted left by 6 − n. The low 6 − n bits are therefore zero.
- R7: For code 7, the result is the 17-bit sum shifted right by one, which drops its least significant bit.
- R8: When an accepted sample has `smp_last_i` high, the result updates at that clock edge and `done_o` is high for the following cycle only. `done_o` is never high without such a sample one cycle earlier.
- R9: `result_o` holds its value in every cycle that does not follow a final sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Clear the sum and capture the configuration |
| osr_code_i | input | 3 | Oversampling code n; 2^n samples per conversion |
| chop_en_i | input | 1 | Enable polarity correction of inverted samples |
| sign_inv_i | input | 1 | Invert the sign of the output |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 10 | Raw unsigned sample |
| smp_inv_i | input | 1 | Sample taken at inverted polarity |
| smp_last_i | input | 1 | Final sample of the conversion |
| result_o | output | 16 | Left-aligned conversion result |
| done_o | output | 1 | One-cycle pulse when the result updates |

## Verification
The embedded assertions check these properties on every cycle:
- the sum is zero after any start;
- an unmirrored sample reaches the adder unchanged;
- done follows only an accepted final sample;
- the result is stable outside done cycles;
- the unused low bits of a fresh result are zero.

Only the bench's scenarios show that the arithmetic value is right. The bench sweeps every oversampling code with every chop and sign setting, using full-scale, zero and mixed sample patterns. It also changes the configuration inputs partway through each conversion and inserts idle gaps, which covers R3 and R5. It checks separately that a sample presented together with start is dropped.

// File: rtl/afmt_pkg.sv
package afmt_pkg;
  localparam int SAMPLE_W = 10;
  localparam int RESULT_W = 16;
  localparam int OSR_W    = 3;
  localparam int MAX_OSR  = (1 << OSR_W) - 1;
  localparam int FRAC_W   = RESULT_W - SAMPLE_W;
  localparam int ACC_W    = SAMPLE_W + MAX_OSR;

  typedef struct packed {
    logic [OSR_W-1:0] osr;
    logic             chop;
    logic             sign;
  } afmt_cfg_t;
endpackage

// File: rtl/afmt_corrector.sv
module afmt_corrector #(
  parameter int SAMPLE_W = 10
) (
  input  logic [SAMPLE_W-1:0] raw_i,
  input  logic                inv_i,
  input  logic                chop_i,
  input  logic                sign_i,
  output logic [SAMPLE_W-1:0] corr_o
);
  logic mirror;

  always_comb begin
    mirror = (chop_i & inv_i) ^ sign_i;
    corr_o = mirror ? ~raw_i : raw_i;
  end
endmodule

// File: rtl/afmt_accum.sv
module afmt_accum #(
  parameter int SAMPLE_W = 10,
  parameter int ACC_W    = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                add_en_i,
  input  logic [SAMPLE_W-1:0] addend_i,
  output logic [ACC_W-1:0]    sum_next_o
);
  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    sum_next_o = acc_q + ACC_W'(addend_i);
    acc_d      = acc_q;
    if (clr_i)         acc_d = '0;
    else if (add_en_i) acc_d = sum_next_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0));
endmodule

// File: rtl/afmt_formatter.sv
module afmt_formatter #(
  parameter int ACC_W    = 17,
  parameter int RESULT_W = 16,
  parameter int FRAC_W   = 6,
  parameter int OSR_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [ACC_W-1:0]    sum_i,
  input  logic [OSR_W-1:0]    osr_i,
  output logic [RESULT_W-1:0] result_o,
  output logic                done_o
);
  localparam int WIDE_W = ACC_W + FRAC_W;

  logic [WIDE_W-1:0]   wide;
  logic [RESULT_W-1:0] result_d, result_q;
  logic                done_d, done_q;
  logic [RESULT_W-1:0] low_mask;

  always_comb begin
    wide     = ({{FRAC_W{1'b0}}, sum_i} << FRAC_W) >> osr_i;
    result_d = load_i ? wide[RESULT_W-1:0] : result_q;
    done_d   = load_i;
    low_mask = '0;
    if (int'(osr_i) <= FRAC_W)
      low_mask = RESULT_W'((1 << (FRAC_W - int'(osr_i))) - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      result_q <= result_d;
      done_q   <= done_d;
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;

  assert_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((result_q & low_mask) == '0));
endmodule

// File: rtl/osr_result_fmt.sv
module osr_result_fmt
  import afmt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [OSR_W-1:0]    osr_code_i,
  input  logic                chop_en_i,
  input  logic                sign_inv_i,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  input  logic                smp_inv_i,
  input  logic                smp_last_i,
  output logic [RESULT_W-1:0] result_o,
  output logic                done_o
);
  logic             rst_s1, rst_s2;
  afmt_cfg_t        cfg_q, cfg_d;
  logic             accept, finish;
  logic [SAMPLE_W-1:0] corr;
  logic [ACC_W-1:0]    sum_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  always_comb begin
    accept = smp_valid_i & ~start_i;
    finish = accept & smp_last_i;
    cfg_d  = cfg_q;
    if (start_i) cfg_d = '{osr: osr_code_i, chop: chop_en_i, sign: sign_inv_i};
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  afmt_corrector #(.SAMPLE_W(SAMPLE_W)) u_corr (
    .raw_i (smp_data_i),
    .inv_i (smp_inv_i),
    .chop_i(cfg_q.chop),
    .sign_i(cfg_q.sign),
    .corr_o(corr)
  );

  afmt_accum #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_s2),
    .clr_i     (start_i),
    .add_en_i  (accept),
    .addend_i  (corr),
    .sum_next_o(sum_next)
  );

  afmt_formatter #(.ACC_W(ACC_W), .RESULT_W(RESULT_W), .FRAC_W(FRAC_W), .OSR_W(OSR_W)) u_fmt (
    .clk     (clk),
    .rst_n   (rst_s2),
    .load_i  (finish),
    .sum_i   (sum_next),
    .osr_i   (cfg_q.osr),
    .result_o(result_o),
    .done_o  (done_o)
  );

  assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_s2)
    (accept && !(cfg_q.chop && smp_inv_i) && !cfg_q.sign) |-> (corr == smp_data_i));

  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_s2)
    done_o |-> $past(smp_valid_i && smp_last_i && !start_i));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_s2)
    !done_o |-> $stable(result_o));
endmodule

// File: tb/osr_result_fmt_tb.sv
module osr_result_fmt_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, chop_en_i, sign_inv_i, smp_valid_i, smp_inv_i, smp_last_i;
  logic [2:0]  osr_code_i;
  logic [9:0]  smp_data_i;
  logic [15:0] result_o;
  logic        done_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  osr_result_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .osr_code_i(osr_code_i),
    .chop_en_i(chop_en_i), .sign_inv_i(sign_inv_i), .smp_valid_i(smp_valid_i),
    .smp_data_i(smp_data_i), .smp_inv_i(smp_inv_i), .smp_last_i(smp_last_i),
    .result_o(result_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fmt(input int sum, input int n);
    if (n <= 6) return (sum << (6 - n)) & 16'hFFFF;
    return (sum >> 1) & 16'hFFFF;
  endfunction

  task automatic run_conv(input int n, input bit chop, input bit sgn, input int kind);
    int cnt = 1 << n;
    int sum = 0;
    int exp_res;
    @(negedge clk);
    start_i = 1'b1; osr_code_i = 3'(n); chop_en_i = chop; sign_inv_i = sgn;
    smp_valid_i = 1'b0; smp_last_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    // R3: disturb the configuration inputs for the rest of the conversion
    osr_code_i = 3'(7 - n); chop_en_i = ~chop; sign_inv_i = ~sgn;
    for (int i = 0; i < cnt; i++) begin
      int s;
      bit p;
      if (i % 3 == 1) begin
        smp_valid_i = 1'b0; smp_data_i = 10'h3FF; smp_inv_i = 1'b0; smp_last_i = 1'b1;
        @(negedge clk);
      end
      if (kind == 0)      s = 1023;
      else if (kind == 1) s = 0;
      else                s = (n * 37 + i * 113 + chop * 7 + sgn * 11) % 1024;
      p = (i % 2) == 1;
      sum += (((chop & p) ^ sgn) != 0) ? (1023 - s) : s;
      smp_valid_i = 1'b1; smp_data_i = 10'(s); smp_inv_i = p;
      smp_last_i = (i == cnt - 1);
      @(negedge clk);
    end
    smp_valid_i = 1'b0; smp_last_i = 1'b0;
    exp_res = fmt(sum, n);
    check("R8 done pulse", int'(done_o), 1);
    if (n == 7) check("R7/R4/R5 result n=7", int'(result_o), exp_res);
    else        check("R6/R4/R5 result", int'(result_o), exp_res);
    @(negedge clk);
    check("R8 done single cycle", int'(done_o), 0);
    check("R9 result held", int'(result_o), exp_res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; osr_code_i = '0; chop_en_i = 1'b0; sign_inv_i = 1'b0;
    smp_valid_i = 1'b0; smp_data_i = '0; smp_inv_i = 1'b0; smp_last_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset result", int'(result_o), 0);
    check("R1 reset done", int'(done_o), 0);

    // R2: sample presented together with start is dropped
    start_i = 1'b1; osr_code_i = 3'd0; smp_valid_i = 1'b1; smp_data_i = 10'h3FF; smp_last_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; smp_data_i = 10'd5;
    @(negedge clk);
    smp_valid_i = 1'b0; smp_last_i = 1'b0;
    check("R2 start sample dropped", int'(result_o), 5 << 6);
    check("R2 done after last", int'(done_o), 1);

    for (int n = 0; n < 8; n++)
      for (int c = 0; c < 2; c++)
        for (int g = 0; g < 2; g++)
          for (int k = 0; k < 3; k++)
            run_conv(n, c[0], g[0], k);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule